// File: doc/BRIEF.md
# Internal Error Reporting Controller

This block gathers single-cycle event pulses from a small set of on-chip error detectors and turns them into internal error reports for a downstream advanced-error-reporting unit. Every source owns a sticky status bit, a mask bit and a severity bit. A newly recorded, unmasked event is sent to the downstream unit as a one-cycle pulse on one of two class outputs: uncorrectable or correctable. The severity bit of the source picks the class.

Software reaches the per-source bits and a global reporting enable through a small register port, with single-cycle writes and combinational reads. Status bits are cleared by writing ones to them. Headers are never captured for these errors, so every uncorrectable report comes with an all-ones header log value. While reporting is disabled, the block drives four lock outputs. These hold the related mask, severity and header-overflow mask fields in the downstream unit read-only.

Top module: `interr_hub`

## Requirements
- R1: After reset, all status and mask bits read 0, and the enable reads 1. Severity reads 4'b1101, where bit 0 is the core time-out source, bit 1 is the single-bit memory ECC source, bit 2 is the double-bit memory ECC source and bit 3 is the data-path parity source. Both report pulses are low and all four lock outputs are low.
- R2: An event pulse sets the matching status bit (address 0) from the next cycle on. The bit stays set until it is cleared by software.
- R3: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. When an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R4: An event on a source whose mask bit (address 1) is 1 still sets its status bit but produces no report pulse.
- R5: An unmasked event on a source whose status bit was 0 raises `unc_pulse` in the cycle after the event if its severity bit (address 2) is 1. It raises `cor_pulse` in that cycle if the severity bit is 0. Sources of both classes in one cycle raise both pulses.
- R6: A report pulse lasts exactly one cycle. An event on a source whose status bit is already 1 produces no new report.
- R7: While the enable (address 3, bit 0) is 0, events still set status bits but no report pulses are produced. Re-enabling produces no report for bits that are already set.
- R8: All four lock outputs equal the inverse of the enable and change in the cycle after the write to the enable.
- R9: `hdr_log` is all ones in each cycle in which `unc_pulse` is 1, and all zeros otherwise.
- R10: The mask, severity and enable registers read back the values written to them. Bits above the source count, and bits above bit 0 of the control register, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt | input | NUM_SRC | Event pulses, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 mask, 2 severity, 3 control |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| unc_pulse | output | 1 | Uncorrectable internal error report |
| cor_pulse | output | 1 | Correctable internal error report |
| hdr_log | output | HDR_W | Header log value sent with uncorrectable reports |
| lock_unc_mask | output | 1 | Locks the downstream uncorrectable-internal mask field |
| lock_unc_sev | output | 1 | Locks the downstream uncorrectable-internal severity field |
| lock_cor_mask | output | 1 | Locks the downstream correctable-internal mask field |
| lock_hovf_mask | output | 1 | Locks the downstream header-overflow mask field |

## Verification
An event or register write that the clock edge samples appears on `reg_rdata` right after that same edge, because reads are combinational. Report pulses, `hdr_log` and the locks change one edge after their cause, and the pulses drop again one edge later. The bench drives inputs on the falling edge and samples on the next falling edge, so every check lands in the cycle in which its result is due. A second sample, one cycle later, confirms that each pulse lasts only one cycle.

// File: rtl/interr_pkg.sv
package interr_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_STATUS = 2'd0,
    RA_MASK   = 2'd1,
    RA_SEV    = 2'd2,
    RA_CTRL   = 2'd3
  } reg_addr_e;

  // source positions
  localparam int SRC_TMO = 0;
  localparam int SRC_SBE = 1;
  localparam int SRC_DBE = 2;
  localparam int SRC_PAR = 3;
endpackage

// File: rtl/interr_rst_sync.sv
module interr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/interr_regs.sv
module interr_regs
  import interr_pkg::*;
#(
  parameter int              NUM_SRC = 4,
  parameter int              DATA_W  = 8,
  parameter logic [NUM_SRC-1:0] SEV_RST = 4'b1101
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic [NUM_SRC-1:0]    status_i,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [NUM_SRC-1:0]    mask_o,
  output logic [NUM_SRC-1:0]    sev_o,
  output logic                  en_o,
  output logic [NUM_SRC-1:0]    clr_o
);
  reg_addr_e addr;
  logic [NUM_SRC-1:0] mask_q, mask_d, sev_q, sev_d;
  logic en_q, en_d;
  logic mask_we, sev_we, en_we;

  assign addr = reg_addr_e'(reg_addr);

  always_comb begin
    mask_we = reg_wr && (addr == RA_MASK);
    sev_we  = reg_wr && (addr == RA_SEV);
    en_we   = reg_wr && (addr == RA_CTRL);
    mask_d  = reg_wdata[NUM_SRC-1:0];
    sev_d   = reg_wdata[NUM_SRC-1:0];
    en_d    = reg_wdata[0];
    clr_o   = (reg_wr && (addr == RA_STATUS)) ? reg_wdata[NUM_SRC-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      sev_q  <= SEV_RST;
      en_q   <= 1'b1;
    end else begin
      if (mask_we) mask_q <= mask_d;
      if (sev_we)  sev_q  <= sev_d;
      if (en_we)   en_q   <= en_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (addr)
      RA_STATUS: reg_rdata[NUM_SRC-1:0] = status_i;
      RA_MASK:   reg_rdata[NUM_SRC-1:0] = mask_q;
      RA_SEV:    reg_rdata[NUM_SRC-1:0] = sev_q;
      RA_CTRL:   reg_rdata[0]           = en_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign sev_o  = sev_q;
  assign en_o   = en_q;

  // R10: a mask write is visible on the next cycle
  assert_mask_write_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    mask_we |=> (mask_o == $past(reg_wdata[NUM_SRC-1:0])));
endmodule

// File: rtl/interr_status.sv
module interr_status #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] st_o,
  output logic [NUM_SRC-1:0] new_o
);
  logic [NUM_SRC-1:0] st_q, st_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_comb begin
      st_d[i]  = evt_i[i] | (st_q[i] & ~clr_i[i]);
      new_o[i] = evt_i[i] & ~st_q[i];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) st_q[i] <= 1'b0;
      else         st_q[i] <= st_d[i];
    end

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_ni)
      evt_i[i] |=> st_q[i]);
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_ni)
      (st_q[i] && !clr_i[i]) |=> st_q[i]);
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_ni)
      (clr_i[i] && !evt_i[i]) |=> !st_q[i]);
  end

  assign st_o = st_q;
endmodule

// File: rtl/interr_route.sv
module interr_route #(
  parameter int NUM_SRC = 4,
  parameter int HDR_W   = 128
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] new_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] sev_i,
  input  logic               en_i,
  output logic               unc_o,
  output logic               cor_o,
  output logic [HDR_W-1:0]   hdr_o
);
  logic [NUM_SRC-1:0] live;
  logic unc_d, cor_d, unc_q, cor_q;
  logic [HDR_W-1:0] hdr_d, hdr_q;

  always_comb begin
    live  = new_i & ~mask_i & {NUM_SRC{en_i}};
    unc_d = |(live & sev_i);
    cor_d = |(live & ~sev_i);
    hdr_d = unc_d ? {HDR_W{1'b1}} : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      unc_q <= 1'b0;
      cor_q <= 1'b0;
      hdr_q <= '0;
    end else begin
      unc_q <= unc_d;
      cor_q <= cor_d;
      hdr_q <= hdr_d;
    end
  end

  assign unc_o = unc_q;
  assign cor_o = cor_q;
  assign hdr_o = hdr_q;

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_i |=> (!unc_q && !cor_q));
  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    ((new_i & ~mask_i) == '0) |=> (!unc_q && !cor_q));
endmodule

// File: rtl/interr_hub.sv
module interr_hub
  import interr_pkg::*;
#(
  parameter int                 NUM_SRC = 4,
  parameter int                 DATA_W  = 8,
  parameter int                 HDR_W   = 128,
  parameter logic [NUM_SRC-1:0] SEV_RST = 4'b1101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] err_evt,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               unc_pulse,
  output logic               cor_pulse,
  output logic [HDR_W-1:0]   hdr_log,
  output logic               lock_unc_mask,
  output logic               lock_unc_sev,
  output logic               lock_cor_mask,
  output logic               lock_hovf_mask
);
  logic rst_ni;
  logic [NUM_SRC-1:0] st, nw, mask, sev, clr;
  logic en;

  interr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ni(rst_ni)
  );

  interr_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .SEV_RST(SEV_RST)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status_i(st), .reg_rdata(reg_rdata),
    .mask_o(mask), .sev_o(sev), .en_o(en), .clr_o(clr)
  );

  interr_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk(clk), .rst_ni(rst_ni), .evt_i(err_evt), .clr_i(clr),
    .st_o(st), .new_o(nw)
  );

  interr_route #(.NUM_SRC(NUM_SRC), .HDR_W(HDR_W)) u_route (
    .clk(clk), .rst_ni(rst_ni), .new_i(nw), .mask_i(mask), .sev_i(sev),
    .en_i(en), .unc_o(unc_pulse), .cor_o(cor_pulse), .hdr_o(hdr_log)
  );

  assign lock_unc_mask  = ~en;
  assign lock_unc_sev   = ~en;
  assign lock_cor_mask  = ~en;
  assign lock_hovf_mask = ~en;

  // R6: every report coincides with a freshly set status bit
  assert_report_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (unc_pulse || cor_pulse) |-> |(st & ~$past(st)));
  assert_lock_follows_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && reg_addr == 2'd3) |=> (lock_unc_mask == !$past(reg_wdata[0])));
  assert_hdr_ones_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    unc_pulse |-> (&hdr_log));
endmodule

// File: tb/test_interr_hub.sv
`timescale 1ns/1ps
module test_interr_hub;
  localparam int NS = 4;
  localparam int DW = 8;
  localparam int HW = 128;

  logic clk = 1'b0;
  logic rst_n;
  logic [NS-1:0] err_evt;
  logic reg_wr;
  logic [1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic unc_pulse, cor_pulse;
  logic [HW-1:0] hdr_log;
  logic lk0, lk1, lk2, lk3;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  interr_hub i_interr_hub (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .unc_pulse(unc_pulse), .cor_pulse(cor_pulse), .hdr_log(hdr_log),
    .lock_unc_mask(lk0), .lock_unc_sev(lk1), .lock_cor_mask(lk2),
    .lock_hovf_mask(lk3)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input longint act, input longint exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic chk_pulses(input string req, input bit eu, input bit ec);
    chk_eq({req, " unc"}, unc_pulse, eu);
    chk_eq({req, " cor"}, cor_pulse, ec);
    chk_eq({req, " R9 hdr"}, (hdr_log == {HW{1'b1}}) ? 1 : (hdr_log == '0 ? 0 : 2), eu);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    rst_n = 1'b0; err_evt = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk_eq("R1 status", v, 0);
    rd(2'd1, v); chk_eq("R1 mask", v, 0);
    rd(2'd2, v); chk_eq("R1 severity", v, 8'h0D);
    rd(2'd3, v); chk_eq("R1 enable", v, 1);
    chk_pulses("R1", 0, 0);
    chk_eq("R1 locks", {lk0, lk1, lk2, lk3}, 0);

    // R10 readback, unused bits zero
    wr(2'd1, 8'hFA); rd(2'd1, v); chk_eq("R10 mask", v, 8'h0A);
    wr(2'd2, 8'hF5); rd(2'd2, v); chk_eq("R10 severity", v, 8'h05);
    wr(2'd3, 8'hFE); rd(2'd3, v); chk_eq("R10 ctrl", v, 0);
    // R8 locks with enable low
    chk_eq("R8 locks set", {lk0, lk1, lk2, lk3}, 4'hF);
    wr(2'd3, 8'h01);
    chk_eq("R8 locks clear", {lk0, lk1, lk2, lk3}, 0);
    wr(2'd1, 8'h00); wr(2'd2, 8'h0D);

    // R2 sticky, R3 write-zero / W1C / collision
    err_evt = 4'b0100; @(negedge clk); err_evt = '0;
    chk_pulses("R5 dbe", 1, 0);
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk_eq("R2 sticky", v, 4'b0100);
    wr(2'd0, 8'h00); rd(2'd0, v); chk_eq("R3 write zero", v, 4'b0100);
    wr(2'd0, 8'h04); rd(2'd0, v); chk_eq("R3 w1c", v, 0);
    err_evt = 4'b0001; @(negedge clk); err_evt = '0;
    chk_pulses("R5 tmo", 1, 0);
    err_evt = 4'b0001; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h01;
    @(negedge clk);
    err_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd0, v); chk_eq("R3 event wins", v, 4'b0001);
    chk_pulses("R6 no repeat", 0, 0);
    wr(2'd0, 8'h0F);
    // event and clear on a clear bit: still set, reported
    err_evt = 4'b0010; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h02;
    @(negedge clk);
    err_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd0, v); chk_eq("R3 event wins clear bit", v, 4'b0010);
    chk_pulses("R5 sbe", 0, 1);
    wr(2'd0, 8'h0F);

    // R7 disabled then re-enabled
    wr(2'd3, 8'h00);
    err_evt = 4'b1111; @(negedge clk); err_evt = '0;
    chk_pulses("R7 disabled", 0, 0);
    rd(2'd0, v); chk_eq("R7 status still set", v, 4'hF);
    wr(2'd3, 8'h01);
    chk_pulses("R7 reenable", 0, 0);
    @(negedge clk);
    chk_pulses("R7 after reenable", 0, 0);
    wr(2'd0, 8'h0F);

    // exhaustive sweep: enable x mask x severity x event pattern
    for (int en = 0; en < 2; en++) begin
      for (int m = 0; m < 16; m++) begin
        for (int s = 0; s < 16; s++) begin
          for (int e = 0; e < 16; e++) begin
            bit eu, ec;
            eu = (en != 0) && ((e & ~m & s & 4'hF) != 0);
            ec = (en != 0) && ((e & ~m & ~s & 4'hF) != 0);
            wr(2'd1, DW'(m)); wr(2'd2, DW'(s)); wr(2'd3, DW'(en)); wr(2'd0, 8'h0F);
            err_evt = NS'(e); @(negedge clk); err_evt = '0;
            chk_pulses("R4 R5 sweep", eu, ec);
            rd(2'd0, v); chk_eq("R2 sweep status", v, e);
            @(negedge clk);
            chk_pulses("R6 one cycle", 0, 0);
            err_evt = NS'(e); @(negedge clk); err_evt = '0;
            chk_pulses("R6 already set", 0, 0);
          end
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule